// File: doc/BRIEF.md
# NAND Command Sequencer

This block turns one write to its command register into a complete NAND flash operation on the raw device pins. The command word enables any subset of five phases. These are a leading opcode byte, a run of one to eight address bytes, a trailing opcode byte, a wait for the device's ready/busy line, and a byte transfer between the device and an internal 1024-byte page buffer. Enabled phases always run in that order, and disabled phases are skipped with no idle cycles between them.

Software programs the address, byte count and trailing opcode in separate registers. It then writes the command word and polls the status register. A busy bit stays set until the operation ends. A sticky completion flag is set at the end and cleared by writing one to it. The page buffer has its own byte-wide port. Firmware uses it to fill the buffer before a program transfer and to drain it after a read transfer. Every command or address byte is a single write-strobe pulse whose low and high widths are a parameter in clock cycles. Read bytes each use one read-strobe pulse of the same shape.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, the control and status registers read 0. The pins are idle: chip enable high, both strobes high, command and address latches low, data output enable low. Whenever chip enable is high, the strobes and latches stay idle.
- R2: Enabled phases run in the fixed order opcode-1, address, opcode-2, ready wait, transfer. Command word bit 22 enables opcode-1, and bits 7:0 give its value, sent with the command latch high. The command and address latches are never high together.
- R3: Command word bit 19 enables the address phase, and bits 18:16 hold the byte count minus one. Bytes leave least significant first from the low address register (offset 0x08), then continue from the high address register (offset 0x0C), each with the address latch high.
- R4: Command word bit 24 enables opcode-2, whose value is bits 7:0 of the read-command-set register (offset 0x18).
- R5: Command word bit 23 enables the ready wait. No later phase starts while the synchronized ready/busy input is low, and the wait lasts at least the configured delay.
- R6: Command word bit 21 with bit 20 clear reads count-register (offset 0x10) bytes. Each byte uses one read-strobe pulse, and byte i is stored at buffer address i. The read and write strobes are never low together.
- R7: Command word bits 21 and 20 both set transfer count-register bytes from buffer addresses 0 upward onto the data pins, one write-strobe pulse each, with no read-strobe pulse. Output enable is never high while the read strobe is low.
- R8: Status bit 1 (offset 0x04) is set when an accepted command finishes, including a command with no phase enabled. Writing 1 to it clears it.
- R9: Status bit 3 reads 1 from the cycle after an accepted command write until it finishes. A command write while it reads 1 is ignored.
- R10: Writing control bit 1 starts a soft reset. The bit reads 1 for the reset duration and then clears itself. The reset aborts any running operation without further strobes, returns the pins to idle (chip enable high the cycle after), and clears busy and completion.
- R11: Control (offset 0x00) bit 0 enables the block, and bits 11:8 hold a page-size code that reads back as written. A command write while bit 0 is clear is ignored.
- R12: Every write-strobe low pulse lasts exactly PULSE_CYC clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | REG_AW | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data (combinational) |
| bufAddr | input | log2(BUF_DEPTH) | Page buffer port address |
| bufWr | input | 1 | Page buffer port write |
| bufWdata | input | 8 | Page buffer port write data |
| bufRdata | output | 8 | Page buffer port read data |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Data to device |
| nandDoe | output | 1 | Output enable for nandDout |
| nandDin | input | 8 | Data from device |
| nandRbN | input | 1 | Ready/busy from device, low = busy |

## Verification
A phase state that advances wrongly shows up on the pins within one byte period, which is 2·PULSE_CYC cycles. It appears as a missing, extra or reordered latch-qualified strobe, or as the wrong byte at the write-strobe rising edge. A broken byte index shows as a wrong address byte, a wrong buffer address after a read, or a wrong number of strobes. A busy or completion state that never clears becomes visible at the next status poll, and so does an operation that cannot start. A reset that fails to abort shows up as read strobes once ready/busy is released.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // register byte offsets
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_STAT = 5'h04;
  localparam logic [4:0] OFS_ADLO = 5'h08;
  localparam logic [4:0] OFS_ADHI = 5'h0C;
  localparam logic [4:0] OFS_CNT  = 5'h10;
  localparam logic [4:0] OFS_CMD  = 5'h14;
  localparam logic [4:0] OFS_RCS  = 5'h18;

  // command word enables
  localparam int B_ADDR = 19;
  localparam int B_DIR  = 20;
  localparam int B_XFER = 21;
  localparam int B_CMD1 = 22;
  localparam int B_WAIT = 23;
  localparam int B_CMD2 = 24;

  typedef enum logic [1:0] {SEL_CMD1, SEL_ADDR, SEL_CMD2, SEL_DATA} byteSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     active;
    logic     clrIdx;
    logic     incIdx;
    logic     capRead;
    logic     setDone;
    logic     clrDone;
    logic     weLow;
    logic     reLow;
    logic     drvCle;
    logic     drvAle;
    logic     drvOut;
    byteSel_e sel;
  } seqStrobe_t;

  // decoded command word for the control
  typedef struct packed {
    logic enCmd1;
    logic enAddr;
    logic enCmd2;
    logic enWait;
    logic enXfer;
    logic dirWrite;
    logic countNz;
  } cmdFields_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int PULSE_CYC = 2,
  parameter int TWB_CYC   = 4,
  parameter int RST_CYC   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic       softRst,
  input  cmdFields_t fields,
  input  logic       lastAddr,
  input  logic       lastXfer,
  input  logic       rbReady,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       resetting
);

  localparam int T2    = 2 * PULSE_CYC;
  localparam int TA    = (T2 > TWB_CYC) ? T2 : TWB_CYC;
  localparam int TMAX  = (TA > RST_CYC) ? TA : RST_CYC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] T_HALF = TMR_W'(PULSE_CYC);
  localparam logic [TMR_W-1:0] T_END  = TMR_W'(T2 - 1);
  localparam logic [TMR_W-1:0] T_WB   = TMR_W'(TWB_CYC);
  localparam logic [TMR_W-1:0] T_RST  = TMR_W'(RST_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_CMD1 = 3'd1, S_ADDR = 3'd2, S_CMD2 = 3'd3,
    S_WAIT = 3'd4, S_XFER = 3'd5, S_DONE = 3'd6, S_RST  = 3'd7
  } state_e;

  state_e           state;
  logic [TMR_W-1:0] tmr;
  logic             byteEnd;
  logic             byteState;
  logic             isRead;

  // first enabled phase strictly after s
  function automatic state_e nextPhase(state_e s, cmdFields_t f);
    state_e n;
    n = S_DONE;
    if (s < S_CMD1 && f.enCmd1)                    n = S_CMD1;
    else if (s < S_ADDR && f.enAddr)               n = S_ADDR;
    else if (s < S_CMD2 && f.enCmd2)               n = S_CMD2;
    else if (s < S_WAIT && f.enWait)               n = S_WAIT;
    else if (s < S_XFER && f.enXfer && f.countNz)  n = S_XFER;
    return n;
  endfunction

  assign byteEnd   = (tmr == T_END);
  assign byteState = (state == S_CMD1) || (state == S_ADDR) ||
                     (state == S_CMD2) || (state == S_XFER);
  assign isRead    = (state == S_XFER) && !fields.dirWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      tmr   <= '0;
    end else if (softRst) begin
      state <= S_RST;
      tmr   <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state <= nextPhase(S_IDLE, fields);
          tmr   <= '0;
        end
        S_CMD1, S_CMD2: if (byteEnd) begin
          state <= nextPhase(state, fields);
          tmr   <= '0;
        end else tmr <= tmr + 1'b1;
        S_ADDR: if (byteEnd) begin
          tmr <= '0;
          if (lastAddr) state <= nextPhase(state, fields);
        end else tmr <= tmr + 1'b1;
        S_XFER: if (byteEnd) begin
          tmr <= '0;
          if (lastXfer) state <= nextPhase(state, fields);
        end else tmr <= tmr + 1'b1;
        S_WAIT: if (tmr >= T_WB && rbReady) begin
          state <= nextPhase(state, fields);
          tmr   <= '0;
        end else if (tmr < T_WB) tmr <= tmr + 1'b1;
        S_DONE: state <= S_IDLE;
        S_RST: if (tmr == T_RST) begin
          state <= S_IDLE;
          tmr   <= '0;
        end else tmr <= tmr + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.active  = (state != S_IDLE) && (state != S_RST);
    stb.clrIdx  = ((state == S_IDLE) && go) || (state == S_RST);
    stb.incIdx  = ((state == S_ADDR) || (state == S_XFER)) && byteEnd;
    stb.capRead = isRead && (tmr == T_HALF);
    stb.setDone = (state == S_DONE);
    stb.clrDone = (state == S_RST);
    stb.weLow   = byteState && !isRead && (tmr < T_HALF);
    stb.reLow   = isRead && (tmr < T_HALF);
    stb.drvCle  = (state == S_CMD1) || (state == S_CMD2);
    stb.drvAle  = (state == S_ADDR);
    stb.drvOut  = byteState && !isRead;
    case (state)
      S_ADDR:  stb.sel = SEL_ADDR;
      S_CMD2:  stb.sel = SEL_CMD2;
      S_XFER:  stb.sel = SEL_DATA;
      default: stb.sel = SEL_CMD1;
    endcase
  end

  assign busy      = (state != S_IDLE) || go;
  assign resetting = (state == S_RST);

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 1024,
  parameter int REG_AW    = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWr,
  input  logic [REG_AW-1:0]            busAddr,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  input  logic [$clog2(BUF_DEPTH)-1:0] bufAddr,
  input  logic                         bufWr,
  input  logic [7:0]                   bufWdata,
  output logic [7:0]                   bufRdata,
  output logic                         nandCeN,
  output logic                         nandCle,
  output logic                         nandAle,
  output logic                         nandWeN,
  output logic                         nandReN,
  output logic [7:0]                   nandDout,
  output logic                         nandDoe,
  input  logic [7:0]                   nandDin,
  input  logic                         nandRbN,
  input  seqStrobe_t                   stb,
  input  logic                         busy,
  input  logic                         resetting,
  output logic                         go,
  output logic                         softRst,
  output cmdFields_t                   fields,
  output logic                         lastAddr,
  output logic                         lastXfer,
  output logic                         rbReady
);

  localparam int BA_W  = $clog2(BUF_DEPTH);
  localparam int CNT_W = BA_W + 1;

  logic             ctrlEn;
  logic [3:0]       pageCode;
  logic [31:0]      addrLo, addrHi, cmdWord;
  logic [23:0]      rcmdReg;
  logic [CNT_W-1:0] countReg, xferIdx;
  logic [2:0]       addrIdx;
  logic             doneFlag;
  logic             rbMeta, rbSync;
  logic [63:0]      addrAll;
  logic [7:0]       outByte;
  logic [7:0]       mem [BUF_DEPTH];
  logic             wrCtrl, wrStat, wrCmd, cmdAccept;

  assign wrCtrl    = busWr && (busAddr == REG_AW'(OFS_CTRL));
  assign wrStat    = busWr && (busAddr == REG_AW'(OFS_STAT));
  assign wrCmd     = busWr && (busAddr == REG_AW'(OFS_CMD));
  assign cmdAccept = wrCmd && ctrlEn && !busy;
  assign softRst   = wrCtrl && busWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      pageCode <= '0;
      addrLo   <= '0;
      addrHi   <= '0;
      countReg <= '0;
      cmdWord  <= '0;
      rcmdReg  <= '0;
      go       <= 1'b0;
    end else begin
      go <= cmdAccept;
      if (wrCtrl) begin
        ctrlEn   <= busWdata[0];
        pageCode <= busWdata[11:8];
      end
      if (busWr && busAddr == REG_AW'(OFS_ADLO)) addrLo   <= busWdata;
      if (busWr && busAddr == REG_AW'(OFS_ADHI)) addrHi   <= busWdata;
      if (busWr && busAddr == REG_AW'(OFS_CNT))  countReg <= busWdata[CNT_W-1:0];
      if (busWr && busAddr == REG_AW'(OFS_RCS))  rcmdReg  <= busWdata[23:0];
      if (cmdAccept) cmdWord <= busWdata;
    end
  end

  // completion flag: set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      doneFlag <= 1'b0;
    else if (stb.setDone)           doneFlag <= 1'b1;
    else if (stb.clrDone)           doneFlag <= 1'b0;
    else if (wrStat && busWdata[1]) doneFlag <= 1'b0;
  end

  // ready/busy synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbMeta <= 1'b0;
      rbSync <= 1'b0;
    end else begin
      rbMeta <= nandRbN;
      rbSync <= rbMeta;
    end
  end
  assign rbReady = rbSync;

  // byte indices
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrIdx <= '0;
      xferIdx <= '0;
    end else if (stb.clrIdx) begin
      addrIdx <= '0;
      xferIdx <= '0;
    end else if (stb.incIdx) begin
      if (stb.sel == SEL_ADDR)      addrIdx <= addrIdx + 1'b1;
      else if (stb.sel == SEL_DATA) xferIdx <= xferIdx + 1'b1;
    end
  end

  assign lastAddr = (addrIdx == cmdWord[18:16]);
  assign lastXfer = (xferIdx == countReg - 1'b1);

  assign fields.enCmd1   = cmdWord[B_CMD1];
  assign fields.enAddr   = cmdWord[B_ADDR];
  assign fields.enCmd2   = cmdWord[B_CMD2];
  assign fields.enWait   = cmdWord[B_WAIT];
  assign fields.enXfer   = cmdWord[B_XFER];
  assign fields.dirWrite = cmdWord[B_DIR];
  assign fields.countNz  = (countReg != '0);

  // page buffer
  always_ff @(posedge clk) begin
    if (stb.capRead)  mem[xferIdx[BA_W-1:0]] <= nandDin;
    else if (bufWr)   mem[bufAddr] <= bufWdata;
  end
  assign bufRdata = mem[bufAddr];

  assign addrAll = {addrHi, addrLo};

  always_comb begin
    case (stb.sel)
      SEL_ADDR: outByte = addrAll[{addrIdx, 3'b000} +: 8];
      SEL_CMD2: outByte = rcmdReg[7:0];
      SEL_DATA: outByte = mem[xferIdx[BA_W-1:0]];
      default:  outByte = cmdWord[7:0];
    endcase
  end

  // registered pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nandCeN  <= 1'b1;
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
      nandWeN  <= 1'b1;
      nandReN  <= 1'b1;
      nandDoe  <= 1'b0;
      nandDout <= '0;
    end else begin
      nandCeN  <= !stb.active;
      nandCle  <= stb.drvCle;
      nandAle  <= stb.drvAle;
      nandWeN  <= !stb.weLow;
      nandReN  <= !stb.reLow;
      nandDoe  <= stb.drvOut;
      nandDout <= stb.drvOut ? outByte : 8'h00;
    end
  end

  always_comb begin
    case (busAddr)
      REG_AW'(OFS_CTRL): busRdata = {20'b0, pageCode, 6'b0, resetting, ctrlEn};
      REG_AW'(OFS_STAT): busRdata = {28'b0, busy, 1'b0, doneFlag, 1'b0};
      REG_AW'(OFS_ADLO): busRdata = addrLo;
      REG_AW'(OFS_ADHI): busRdata = addrHi;
      REG_AW'(OFS_CNT):  busRdata = 32'(countReg);
      REG_AW'(OFS_CMD):  busRdata = cmdWord;
      REG_AW'(OFS_RCS):  busRdata = {8'b0, rcmdReg};
      default:           busRdata = '0;
    endcase
  end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 1024,
  parameter int PULSE_CYC = 2,
  parameter int TWB_CYC   = 4,
  parameter int RST_CYC   = 8,
  parameter int REG_AW    = 5
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busWr,
  input  logic [REG_AW-1:0]            busAddr,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  input  logic [$clog2(BUF_DEPTH)-1:0] bufAddr,
  input  logic                         bufWr,
  input  logic [7:0]                   bufWdata,
  output logic [7:0]                   bufRdata,
  output logic                         nandCeN,
  output logic                         nandCle,
  output logic                         nandAle,
  output logic                         nandWeN,
  output logic                         nandReN,
  output logic [7:0]                   nandDout,
  output logic                         nandDoe,
  input  logic [7:0]                   nandDin,
  input  logic                         nandRbN
);

  seqStrobe_t stb;
  cmdFields_t fields;
  logic       busyFlag, rstActive, go, softRst;
  logic       lastAddr, lastXfer, rbReady;

  nand_seq_ctrl #(
    .PULSE_CYC(PULSE_CYC), .TWB_CYC(TWB_CYC), .RST_CYC(RST_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .softRst(softRst), .fields(fields),
    .lastAddr(lastAddr), .lastXfer(lastXfer), .rbReady(rbReady),
    .stb(stb), .busy(busyFlag), .resetting(rstActive)
  );

  nand_seq_dp #(
    .BUF_DEPTH(BUF_DEPTH), .REG_AW(REG_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .bufAddr(bufAddr), .bufWr(bufWr), .bufWdata(bufWdata), .bufRdata(bufRdata),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe), .nandDin(nandDin),
    .nandRbN(nandRbN), .stb(stb), .busy(busyFlag), .resetting(rstActive),
    .go(go), .softRst(softRst), .fields(fields), .lastAddr(lastAddr),
    .lastXfer(lastXfer), .rbReady(rbReady)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int PULSE_CYC = 2
) (
  input logic clk,
  input logic rstN,
  input logic nandCle,
  input logic nandAle,
  input logic nandWeN,
  input logic nandReN,
  input logic nandCeN,
  input logic nandDoe,
  input logic busyFlag,
  input logic rstActive
);

  logic [7:0] weRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         weRun <= '0;
    else if (nandWeN)  weRun <= '0;
    else if (weRun != 8'hFF) weRun <= weRun + 1'b1;
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rstN)
    nandCeN |-> (nandWeN && nandReN && !nandCle && !nandAle && !nandDoe)); // R1

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R6

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDoe); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rstActive |=> nandCeN); // R10

  AST_RESET_NOT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rstActive |-> busyFlag); // R9

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN || rstActive)
    $rose(nandWeN) |-> (weRun == 8'(PULSE_CYC))); // R12

endmodule

bind nand_cmd_seq nand_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .nandCle(nandCle), .nandAle(nandAle),
  .nandWeN(nandWeN), .nandReN(nandReN), .nandCeN(nandCeN), .nandDoe(nandDoe),
  .busyFlag(busyFlag), .rstActive(rstActive)
);

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/100ps
module sim_nand_cmd_seq;

  localparam int PULSE = 2;
  localparam int RSTC  = 8;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_ADLO = 5'h08,
                         A_ADHI = 5'h0C, A_CNT = 5'h10, A_CMD = 5'h14, A_RCS = 5'h18;

  logic        clk = 0, rstN = 0;
  logic        busWr = 0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [9:0]  bufAddr = '0;
  logic        bufWr = 0;
  logic [7:0]  bufWdata = '0, bufRdata;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic [7:0]  nandDout, nandDin;
  logic        nandRbN = 1;

  int nChecks = 0, nFail = 0;
  int evN = 0, rdIdx = 0, weRunB = 0, lastWeW = 0;
  logic [1:0] evKind [64];
  logic [7:0] evByte [64];

  always #2.5 clk = ~clk;

  nand_cmd_seq #(.PULSE_CYC(PULSE), .RST_CYC(RSTC)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .bufAddr(bufAddr), .bufWr(bufWr), .bufWdata(bufWdata),
    .bufRdata(bufRdata), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .nandRbN(nandRbN)
  );

  function automatic logic [7:0] rdPat(int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  // device model
  assign nandDin = rdPat(rdIdx);
  always @(posedge nandReN) if (rstN) rdIdx++;
  always @(posedge nandWeN) begin
    if (rstN && !nandCeN && evN < 64) begin
      evKind[evN] = nandCle ? 2'd1 : (nandAle ? 2'd2 : 2'd3);
      evByte[evN] = nandDout;
      evN++;
    end
  end
  always @(negedge clk) begin
    if (!nandWeN) weRunB++;
    else begin
      if (weRunB != 0) lastWeW = weRunB;
      weRunB = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk); busWr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int k = 0; k < 500; k++) begin
      rd(A_STAT, s);
      if (!s[3]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    check("R1 pins", {nandCeN, nandWeN, nandReN, nandCle, nandAle, nandDoe}, 32'b111000);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(A_CTRL, 32'h0000_0301);
    rd(A_CTRL, v); check("R11 ctrl readback", v, 32'h301);
  endtask

  task automatic t_cmdOnly();
    logic [31:0] v; int e0;
    e0 = evN;
    wr(A_CMD, (1 << 22) | 32'hFF);
    waitIdle();
    check("R2 one byte", evN - e0, 1);
    check("R2 cle kind", evKind[e0], 1);
    check("R2 opcode", evByte[e0], 8'hFF);
    check("R12 we width", lastWeW, PULSE);
    rd(A_STAT, v); check("R8 done set", v, 32'h2);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R8 done cleared", v, 0);
  endtask

  task automatic t_fullRead();
    logic [31:0] v; int e0, r0;
    logic [7:0] expB [7];
    expB = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h30};
    wr(A_ADLO, 32'h4433_2211); wr(A_ADHI, 32'h55); wr(A_RCS, 32'h00E0_0530);
    wr(A_CNT, 6);
    nandRbN = 0; e0 = evN; r0 = rdIdx;
    wr(A_CMD, (1 << 22) | (1 << 19) | (4 << 16) | (1 << 24) | (1 << 23) | (1 << 21));
    repeat (80) @(negedge clk);
    check("R5 no read while busy", rdIdx - r0, 0);
    check("R2 byte count", evN - e0, 7);
    for (int i = 0; i < 7; i++) begin
      check((i == 0 || i == 6) ? "R4 opcode kind" : "R3 addr kind", evKind[e0+i],
            (i == 0 || i == 6) ? 1 : 2);
      check(i == 6 ? "R4 second opcode" : "R3 byte order", evByte[e0+i], expB[i]);
    end
    rd(A_STAT, v); check("R9 busy while waiting", v[3], 1);
    nandRbN = 1;
    waitIdle();
    check("R6 read strobes", rdIdx - r0, 6);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bufAddr = 10'(i); #1;
      check("R6 buffer byte", bufRdata, rdPat(r0 + i));
    end
    wr(A_STAT, 2);
  endtask

  task automatic t_busyIgnore();
    logic [31:0] v; int e0;
    nandRbN = 0; e0 = evN;
    wr(A_CMD, (1 << 22) | (1 << 23) | 32'h70);
    rd(A_STAT, v); check("R9 busy bit", v[3], 1);
    wr(A_CMD, (1 << 22) | 32'h90);
    repeat (20) @(negedge clk);
    nandRbN = 1;
    waitIdle();
    repeat (10) @(negedge clk);
    check("R9 ignored cmd count", evN - e0, 1);
    check("R9 first opcode kept", evByte[e0], 8'h70);
    wr(A_STAT, 2);
  endtask

  task automatic t_write();
    int e0, r0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); bufAddr = 10'(i); bufWdata = 8'hC0 + 8'(i); bufWr = 1;
    end
    @(negedge clk); bufWr = 0;
    wr(A_CNT, 4);
    e0 = evN; r0 = rdIdx;
    wr(A_CMD, (1 << 21) | (1 << 20));
    waitIdle();
    check("R7 byte count", evN - e0, 4);
    for (int i = 0; i < 4; i++) begin
      check("R7 data kind", evKind[e0+i], 3);
      check("R7 data byte", evByte[e0+i], 8'hC0 + 8'(i));
    end
    check("R7 no read strobe", rdIdx - r0, 0);
    wr(A_STAT, 2);
  endtask

  task automatic t_addr8();
    int e0;
    wr(A_ADLO, 32'h0403_0201); wr(A_ADHI, 32'h0807_0605);
    e0 = evN;
    wr(A_CMD, (1 << 19) | (7 << 16));
    waitIdle();
    check("R3 eight bytes", evN - e0, 8);
    for (int i = 0; i < 8; i++)
      check("R3 lsb first", {evKind[e0+i], evByte[e0+i]}, {2'd2, 8'(i + 1)});
    wr(A_STAT, 2);
  endtask

  task automatic t_empty();
    logic [31:0] v; int e0;
    e0 = evN;
    wr(A_CMD, 0);
    waitIdle();
    check("R8 empty no strobes", evN - e0, 0);
    rd(A_STAT, v); check("R8 empty done", v, 32'h2);
    wr(A_STAT, 2);
  endtask

  task automatic t_disabled();
    logic [31:0] v; int e0;
    wr(A_CTRL, 32'h100);
    e0 = evN;
    wr(A_CMD, (1 << 22) | 32'hAB);
    repeat (10) @(negedge clk);
    rd(A_STAT, v); check("R11 disabled no busy", v, 0);
    check("R11 disabled no strobes", evN - e0, 0);
    wr(A_CTRL, 32'h101);
  endtask

  task automatic t_softReset();
    logic [31:0] v; int r0;
    nandRbN = 0;
    wr(A_CNT, 3);
    r0 = rdIdx;
    wr(A_CMD, (1 << 23) | (1 << 21));
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h103);
    rd(A_CTRL, v); check("R10 reset bit set", v[1], 1);
    repeat (RSTC + 4) @(negedge clk);
    rd(A_CTRL, v); check("R10 reset bit cleared", v, 32'h101);
    rd(A_STAT, v); check("R10 status cleared", v, 0);
    check("R10 pins idle", {nandCeN, nandReN}, 2'b11);
    nandRbN = 1;
    repeat (30) @(negedge clk);
    check("R10 aborted", rdIdx - r0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    t_reset();
    t_ctrl();
    t_cmdOnly();
    t_fullRead();
    t_busyIgnore();
    t_write();
    t_addr8();
    t_empty();
    t_disabled();
    t_softReset();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule